// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous request port and a 1M x 8 static RAM with no clock of its own. A master offers one word per request through a valid/ready handshake, and the controller turns that request into the strobe pattern the RAM needs. That pattern uses two selects of opposite polarity, an active-low write strobe, an active-low output enable and a shared data bus. The shared bus is split into three signals: the value driven, the value sampled and a drive enable.

Every strobe width and gap is a cycle count. It is derived at elaboration from the clock period `CLK_NS` and from the RAM's minimum nanosecond timings, always rounding up. With the default 8 ns clock this gives these counts:

- write pulse: 7 cycles
- write recovery: 3 cycles
- read access: 7 cycles
- read release: 3 cycles

A `standby` input puts the RAM into its low-power deselected state between accesses.

The state machine has five states:

- `ST_IDLE`: the chip is selected with its output disabled, or deselected under standby.
- `ST_WR_PULSE`: the write strobe is low and the data bus is driven.
- `ST_WR_RECOV`: the strobe is high, the bus is released and the cycle time is completed.
- `ST_RD_ACCESS`: the output enable is low while the access time elapses.
- `ST_RD_RELEASE`: the output enable is high while the RAM output floats.

The transitions are:

- accept-write: `ST_IDLE` to `ST_WR_PULSE`
- accept-read: `ST_IDLE` to `ST_RD_ACCESS`
- pulse-done: `ST_WR_PULSE` to `ST_WR_RECOV`
- recovery-done: `ST_WR_RECOV` to `ST_IDLE`
- capture: `ST_RD_ACCESS` to `ST_RD_RELEASE`
- release-done: `ST_RD_RELEASE` to `ST_IDLE`

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, the RAM is deselected (`ram_sel_lo_n`=1, `ram_sel_hi`=0), both strobes are high, the bus is not driven and `rsp_valid` is 0. One clock after reset falls with `standby` low, the RAM is selected with both strobes high and `req_ready` is 1.
- R2: A request accepted with `req_we`=1 holds `ram_we_n` low for exactly ceil(max(40,50,25)/CLK_NS) cycles, which is 7 at 8 ns. During that pulse the RAM is selected, the bus is driven, and the address and data are those of the request. The word is stored in the RAM.
- R3: When the write strobe rises, the bus drive is dropped. `req_ready` stays low for max(ceil(55/CLK_NS) minus the pulse count, ceil(20/CLK_NS), 1) further cycles, which is 3 at 8 ns.
- R4: A request accepted with `req_we`=0 holds `ram_oe_n` low for ceil(55/CLK_NS) cycles, which is 7. The data bus is sampled at the clock edge where that count ends, and `rsp_valid` is high for exactly the following cycle with the sampled byte on `rsp_rdata`.
- R5: `ram_oe_n` is never low while `ram_dq_oe` is high. After a read, at least ceil(20/CLK_NS) cycles pass with the output enable high before the controller drives the bus again or becomes ready.
- R6: While `standby` is high in `ST_IDLE`, the RAM is deselected and `req_ready` is 0. A request presented then causes no write strobe, no output enable and no change to RAM contents.
- R7: `req_ready` is high only in `ST_IDLE`, so a request offered during an access waits until the access has fully completed.
- R8: `ram_addr` and `ram_dq_out` stay constant from the accepting edge until the controller returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Deselect the RAM while idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 20 | RAM address pins |
| ram_sel_lo_n | output | 1 | Active-low chip select |
| ram_sel_hi | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | 8 | Value driven onto the data bus |
| ram_dq_in | input | 8 | Value sampled from the data bus |
| ram_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The main function is exercised by a table of writes and reads. It covers the lowest and highest addresses and mixed bit patterns, and it overwrites a word before reading it again. Reading back after an overwrite separates a real commit at the end of the write strobe from stale data. Back-to-back read-then-write and write-then-read pairs run with no idle gap, which exposes any missing bus-turnaround cycles. Strobe widths and response latency are counted on every access, so a mis-rounded cycle count shows up even when the data is right. A request held through standby is followed by a read-back, which shows whether the blocked write leaked into memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS,
        ST_RD_RELEASE
    } ctl_state_t;

    // Minimum time in ns to whole clock cycles, rounded up.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The last cycle of a loaded interval.
    assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= din;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS  = 8,
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned T_WC_NS = 55,
    parameter int unsigned T_WP_NS = 40,
    parameter int unsigned T_AW_NS = 50,
    parameter int unsigned T_DW_NS = 25,
    parameter int unsigned T_RC_NS = 55,
    parameter int unsigned T_AA_NS = 55,
    parameter int unsigned T_OE_NS = 35,
    parameter int unsigned T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_lo_n,
    output logic              ram_sel_hi,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              ram_dq_oe
);
    // Derived cycle counts
    localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
    localparam int unsigned HZ_CYC   = umax(ns2cyc(T_HZ_NS, CLK_NS), 1);
    localparam int unsigned WP_CYC   = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                            umax(ns2cyc(T_DW_NS, CLK_NS), 1));
    localparam int unsigned WC_LEFT  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 0;
    localparam int unsigned REC_CYC  = umax(WC_LEFT, HZ_CYC);
    localparam int unsigned RD_CYC   = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                            umax(ns2cyc(T_RC_NS, CLK_NS), 1));
    localparam int unsigned REL_CYC  = HZ_CYC;
    localparam int unsigned MAX_CYC  = umax(umax(WP_CYC, REC_CYC), umax(RD_CYC, REL_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    ctl_state_t        state_q, state_d;
    logic              tmr_load, tmr_expire;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept, capture;
    logic              busy;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .din     (ram_dq_in),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    assign req_ready = (state_q == ST_IDLE) && !standby;
    assign busy      = (state_q != ST_IDLE);

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_we) begin
                        state_d = ST_WR_PULSE;
                        tmr_val = CNT_W'(WP_CYC);
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expire) begin
                    state_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC);
                end
            end
            ST_WR_RECOV: begin
                if (tmr_expire) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expire) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REL_CYC);
                end
            end
            ST_RD_RELEASE: begin
                if (tmr_expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request hold registers
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign ram_addr   = addr_q;
    assign ram_dq_out = wdata_q;

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_sel_lo_n <= 1'b1;
            ram_sel_hi   <= 1'b0;
            ram_we_n     <= 1'b1;
            ram_oe_n     <= 1'b1;
            ram_dq_oe    <= 1'b0;
        end else begin
            ram_sel_lo_n <= 1'b0;
            ram_sel_hi   <= 1'b1;
            ram_we_n     <= 1'b1;
            ram_oe_n     <= 1'b1;
            ram_dq_oe    <= 1'b0;
            unique case (state_d)
                ST_IDLE: begin
                    ram_sel_lo_n <= standby;
                    ram_sel_hi   <= !standby;
                end
                ST_WR_PULSE: begin
                    ram_we_n  <= 1'b0;
                    ram_dq_oe <= 1'b1;
                end
                ST_WR_RECOV:   ram_we_n <= 1'b1;
                ST_RD_ACCESS:  ram_oe_n <= 1'b0;
                ST_RD_RELEASE: ram_oe_n <= 1'b1;
                default:       ram_we_n <= 1'b1;
            endcase
        end
    end

    // R5
    no_contend_chk: assert property (@(posedge clk) disable iff (rst)
        !(ram_dq_oe && !ram_oe_n));

    // R2
    write_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_sel_lo_n && ram_sel_hi && ram_dq_oe));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ram_addr) && $stable(ram_dq_out)));

    // R6
    standby_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && standby) |=> (ram_sel_lo_n && !ram_sel_hi));

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
    localparam int PULSE = 7; // ceil(max(40,50,25)/8)
    localparam int REC   = 3; // max(ceil(55/8)-7, ceil(20/8))
    localparam int RDC   = 7; // ceil(55/8)
    localparam int HZ    = 3; // ceil(20/8)
    localparam int NVEC  = 12;

    // {is_write, addr, wdata, expected read}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b1, 20'h00000, 8'h3C, 8'h00},
        {1'b1, 20'hFFFFF, 8'hA5, 8'h00},
        {1'b1, 20'h5A5A5, 8'h0F, 8'h00},
        {1'b1, 20'h12345, 8'hF0, 8'h00},
        {1'b0, 20'h00000, 8'h00, 8'h3C},
        {1'b0, 20'hFFFFF, 8'h00, 8'hA5},
        {1'b1, 20'h00000, 8'h81, 8'h00},
        {1'b0, 20'h00000, 8'h00, 8'h81},
        {1'b0, 20'h5A5A5, 8'h00, 8'h0F},
        {1'b0, 20'h12345, 8'h00, 8'hF0},
        {1'b1, 20'h12345, 8'h7E, 8'h00},
        {1'b0, 20'h12345, 8'h00, 8'h7E}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [19:0] ram_addr;
    logic        ram_sel_lo_n, ram_sel_hi, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  ram_dq_out, ram_dq_in;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sram_ctl u0 (
        .clk(clk), .rst(rst), .standby(standby),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_sel_lo_n(ram_sel_lo_n), .ram_sel_hi(ram_sel_hi),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .ram_dq_out(ram_dq_out), .ram_dq_in(ram_dq_in), .ram_dq_oe(ram_dq_oe)
    );

    // RAM model
    logic [7:0] model_mem [logic [19:0]];
    logic [7:0] model_rd = 8'h00;

    always @(posedge ram_we_n) begin
        if (!ram_sel_lo_n && ram_sel_hi) model_mem[ram_addr] = ram_dq_out;
    end

    always @(negedge clk) begin
        model_rd <= model_mem.exists(ram_addr) ? model_mem[ram_addr] : 8'h00;
    end

    assign ram_dq_in = (!ram_sel_lo_n && ram_sel_hi && !ram_oe_n && ram_we_n) ? model_rd : 8'h00;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Turnaround monitor (R5)
    int  cyc = 0;
    int  last_oe = -100;
    int  last_drv = -100;
    logic prev_drv = 1'b0;
    logic prev_oe_n = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ram_dq_oe && !prev_drv)
                check(cyc - last_oe > HZ, "R5 read-to-drive gap", cyc - last_oe, HZ + 1);
            if (!ram_oe_n && prev_oe_n)
                check(cyc - last_drv > HZ, "R5 drive-to-read gap", cyc - last_drv, HZ + 1);
            if (!ram_oe_n && ram_dq_oe)
                check(1'b0, "R5 contention", 1, 0);
        end
        if (!ram_oe_n) last_oe = cyc;
        if (ram_dq_oe) last_drv = cyc;
        prev_drv  = ram_dq_oe;
        prev_oe_n = ram_oe_n;
    end

    // Called at a negedge; returns at the negedge where the block is ready again.
    task automatic do_access(input logic we, input logic [19:0] a, input logic [7:0] d,
                             input logic [7:0] exp);
        int we_cnt = 0;
        int oe_cnt = 0;
        int lat = 0;
        logic [7:0] got = 8'h00;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        for (int i = 1; i <= PULSE + REC + 1; i++) begin
            if (!ram_we_n) begin
                we_cnt++;
                check(ram_addr == a && ram_dq_out == d, "R8 held addr/data", {ram_addr, ram_dq_out}, {a, d});
            end
            if (!ram_oe_n) oe_cnt++;
            if (rsp_valid && lat == 0) begin lat = i; got = rsp_rdata; end
            if (i <= PULSE + REC)
                check(!req_ready, "R7 ready low while busy", req_ready, 0);
            if (we && i == PULSE + 1)
                check(!ram_dq_oe && ram_we_n, "R3 bus released after pulse", ram_dq_oe, 0);
            if (i == PULSE + REC + 1)
                check(req_ready, we ? "R3 ready after recovery" : "R5 ready after release", req_ready, 1);
            else @(negedge clk);
        end
        if (we) begin
            check(we_cnt == PULSE, "R2 write pulse width", we_cnt, PULSE);
            check(oe_cnt == 0, "R2 no OE during write", oe_cnt, 0);
        end else begin
            check(oe_cnt == RDC, "R4 OE width", oe_cnt, RDC);
            check(lat == RDC + 1, "R4 rvalid latency", lat, RDC + 1);
            check(got == exp, "R4 read data", got, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ram_sel_lo_n && !ram_sel_hi && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
              "R1 reset outputs", {ram_sel_lo_n, ram_sel_hi, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 6'b101100);
        rst = 1'b0;
        @(negedge clk);
        check(!ram_sel_lo_n && ram_sel_hi && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready,
              "R1 selected idle", {ram_sel_lo_n, ram_sel_hi, ram_we_n, ram_oe_n, ram_dq_oe, req_ready}, 6'b011101);

        // Main table, back to back (R2, R4)
        for (int v = 0; v < NVEC; v++) begin
            do_access(VEC[v][36], VEC[v][35:16], VEC[v][15:8], VEC[v][7:0]);
        end

        // R6 standby
        standby = 1'b1;
        @(negedge clk);
        check(ram_sel_lo_n && !ram_sel_hi && !req_ready, "R6 standby deselect",
              {ram_sel_lo_n, ram_sel_hi, req_ready}, 3'b100);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 20'h00000; req_wdata = 8'hEE;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ram_we_n && ram_oe_n && !rsp_valid, "R6 no strobe in standby",
                  {ram_we_n, ram_oe_n, rsp_valid}, 3'b110);
        end
        req_valid = 1'b0;
        standby = 1'b0;
        @(negedge clk);
        check(!ram_sel_lo_n && ram_sel_hi, "R6 reselect after standby", {ram_sel_lo_n, ram_sel_hi}, 2'b01);
        do_access(1'b0, 20'h00000, 8'h00, 8'h81); // R6 memory untouched

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule